// File: doc/BRIEF.md
# GPIO Event-Driven Output Executor

This block owns a bank of general-purpose output levels that software never writes directly. The levels change only when a peripheral event-to-task interconnect delivers a one-cycle task pulse with a numeric task identifier. Each identifier names one of eight task channels and one of three actions: force high, force low, or invert.

A small configuration space, written over a plain register bus, binds each pin to one channel and enables it. Each pin has a packed 8-bit field, and four fields share one 32-bit word. When a pulse arrives, every enabled pin bound to the decoded channel carries out the action on the next clock edge. Several pins may follow the same channel. Pins on other channels and disabled pins keep their level.

Top module: `gpio_task_exec`

## Requirements
- R1: After reset every pin output is low and every configuration word reads zero.
- R2: Pin p has an 8-bit field in configuration word p/4, starting at bit 8*(p mod 4). Bit 0 of the field is the enable, and bits 3:1 hold the bound channel number (0 to 7). A write to word address A updates pins 4A to 4A+3, and a read of address A returns them in the same layout.
- R3: Bits 7:4 of every field are reserved. They are discarded on write and read as zero.
- R4: Task ID 1+C (C = 0 to 7) drives every enabled pin bound to channel C high.
- R5: Task ID 9+C drives every enabled pin bound to channel C low.
- R6: Task ID 17+C inverts every enabled pin bound to channel C.
- R7: A pulse with task ID 0 or an ID above 24 changes no output.
- R8: A pin whose enable bit is clear keeps its level whatever pulses arrive.
- R9: All enabled pins bound to the pulsed channel act on the same pulse, and pins bound to other channels keep their level.
- R10: A register write and a task pulse in the same cycle act on the configuration as it was before that write.
- R11: An output changes at the clock edge that samples the pulse. It does not change before that edge and is visible right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 3 | Configuration word address for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | 3 | Configuration word address for reads |
| cfg_rdata | output | 32 | Read data for the addressed word, reserved bits zero |
| task_valid | input | 1 | One-cycle task pulse strobe |
| task_id | input | 5 | Task identifier carried by the pulse |
| pin_out | output | 32 | Registered pin output levels |

## Verification
Directed patterns put several pins on one channel, one pin on a neighbouring channel and one disabled pin on the same channel. This separates the per-channel fan-out from the enable gating, and set, clear and toggle are each applied to that arrangement. Boundary IDs 0, 25 and 31 show that out-of-range identifiers are rejected rather than wrapped onto a channel. A write that rebinds a pin in the same cycle as a pulse shows whether the old or the new binding is used. A long random run mixes writes, including reserved bits, with all 32 identifier values and compares every output and readback against a bench model.

// File: rtl/gte_pkg.sv
package gte_pkg;
  localparam int NUM_CH     = 8;
  localparam int CH_W       = 3;
  localparam int TID_W      = 5;
  localparam int FIELD_W    = 8;
  localparam int LANES      = 4;
  localparam int SET_BASE   = 1;
  localparam int CLR_BASE   = SET_BASE + NUM_CH;
  localparam int TGL_BASE   = CLR_BASE + NUM_CH;
  localparam int TID_LAST   = TGL_BASE + NUM_CH - 1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;
endpackage

// File: rtl/gte_cfg_regs.sv
module gte_cfg_regs
  import gte_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = $clog2(NUM_PINS / LANES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [LANES*FIELD_W-1:0]      wdata,
  input  logic [ADDR_W-1:0]             raddr,
  output logic [LANES*FIELD_W-1:0]      rdata,
  output logic [NUM_PINS-1:0]           en_o,
  output logic [NUM_PINS-1:0][CH_W-1:0] ch_o
);
  localparam int WORD_W = LANES * FIELD_W;

  logic [NUM_PINS-1:0]           en_q, en_d;
  logic [NUM_PINS-1:0][CH_W-1:0] ch_q, ch_d;
  logic [NUM_PINS-1:0]           upd;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / LANES;
    localparam int LSB  = FIELD_W * (p % LANES);
    assign upd[p]  = we && (waddr == ADDR_W'(WORD));
    always_comb begin
      en_d[p] = en_q[p];
      ch_d[p] = ch_q[p];
      if (upd[p]) begin
        en_d[p] = wdata[LSB];
        ch_d[p] = wdata[LSB+1 +: CH_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      ch_q <= '0;
    end else begin
      en_q <= en_d;
      ch_q <= ch_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int l = 0; l < LANES; l++) begin
      rdata[FIELD_W*l]              = en_q[int'(raddr)*LANES + l];
      rdata[FIELD_W*l+1 +: CH_W]    = ch_q[int'(raddr)*LANES + l];
    end
  end

  assign en_o = en_q;
  assign ch_o = ch_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & {LANES{8'hF0}}) == '0); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == raddr) |=> ((rdata & {LANES{8'h0F}}) == ($past(wdata) & {LANES{8'h0F}})
                                 || $past(waddr) != raddr)); // R2
endmodule

// File: rtl/gte_task_dec.sv
module gte_task_dec
  import gte_pkg::*;
(
  input  logic             valid,
  input  logic [TID_W-1:0] id,
  output logic             hit,
  output act_e             act,
  output logic [CH_W-1:0]  chan
);
  int unsigned idv;

  always_comb begin
    idv  = int'(id);
    hit  = 1'b0;
    act  = ACT_NONE;
    chan = '0;
    if (valid) begin
      if (idv >= SET_BASE && idv < CLR_BASE) begin
        hit = 1'b1; act = ACT_SET; chan = CH_W'(idv - SET_BASE);
      end else if (idv >= CLR_BASE && idv < TGL_BASE) begin
        hit = 1'b1; act = ACT_CLR; chan = CH_W'(idv - CLR_BASE);
      end else if (idv >= TGL_BASE && idv <= TID_LAST) begin
        hit = 1'b1; act = ACT_TGL; chan = CH_W'(idv - TGL_BASE);
      end
    end
  end

  always_comb begin
    AST_DEC_ONLY_IF_VALID: assert (valid || !hit); // R7
  end
endmodule

// File: rtl/gte_pin_bank.sv
module gte_pin_bank
  import gte_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PINS-1:0]           en,
  input  logic [NUM_PINS-1:0][CH_W-1:0] ch,
  input  logic                          hit,
  input  act_e                          act,
  input  logic [CH_W-1:0]               chan,
  output logic [NUM_PINS-1:0]           q
);
  logic [NUM_PINS-1:0] q_d, sel;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign sel[p] = hit && en[p] && (ch[p] == chan);
    always_comb begin
      q_d[p] = q[p];
      if (sel[p]) begin
        unique case (act)
          ACT_SET: q_d[p] = 1'b1;
          ACT_CLR: q_d[p] = 1'b0;
          ACT_TGL: q_d[p] = ~q[p];
          default: q_d[p] = q[p];
        endcase
      end
    end

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en[p] |=> $stable(q[p])); // R8
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && en[p] && ch[p] == chan && act == ACT_SET) |=> q[p]); // R4
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && en[p] && ch[p] == chan && act == ACT_CLR) |=> !q[p]); // R5
    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && en[p] && ch[p] == chan && act == ACT_TGL) |=> q[p] != $past(q[p])); // R6
    AST_OTHER_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ch[p] != chan) |=> $stable(q[p])); // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/gpio_task_exec.sv
module gpio_task_exec
  import gte_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = $clog2(NUM_PINS / LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_waddr,
  input  logic [LANES*FIELD_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0]        cfg_raddr,
  output logic [LANES*FIELD_W-1:0] cfg_rdata,
  input  logic                     task_valid,
  input  logic [TID_W-1:0]         task_id,
  output logic [NUM_PINS-1:0]      pin_out
);
  logic [NUM_PINS-1:0]           pin_en;
  logic [NUM_PINS-1:0][CH_W-1:0] pin_ch;
  logic                          dec_hit;
  act_e                          dec_act;
  logic [CH_W-1:0]               dec_chan;

  gte_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .en_o(pin_en), .ch_o(pin_ch)
  );

  gte_task_dec u_dec (
    .valid(task_valid), .id(task_id), .hit(dec_hit), .act(dec_act), .chan(dec_chan)
  );

  gte_pin_bank #(.NUM_PINS(NUM_PINS)) u_bank (
    .clk(clk), .rst_n(rst_n), .en(pin_en), .ch(pin_ch), .hit(dec_hit),
    .act(dec_act), .chan(dec_chan), .q(pin_out)
  );

  AST_BAD_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (task_valid && (task_id == '0 || int'(task_id) > TID_LAST)) |=> $stable(pin_out)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !task_valid |=> $stable(pin_out)); // R11
endmodule

// File: tb/tb_gpio_task_exec.sv
`timescale 1ns/1ps
module tb_gpio_task_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_waddr, cfg_raddr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        task_valid;
  logic [4:0]  task_id;
  logic [31:0] pin_out;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_cfg [8];
  logic [31:0] m_pin;

  always #2.5 clk = ~clk;

  gpio_task_exec dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .task_valid(task_valid), .task_id(task_id), .pin_out(pin_out)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] pins, input logic v, input logic [4:0] id);
    logic [31:0] r = pins;
    int kind, c;
    if (!v || id == 0 || id > 24) return r;
    kind = (int'(id) - 1) / 8;
    c    = (int'(id) - 1) % 8;
    for (int p = 0; p < 32; p++) begin
      logic [7:0] f = m_cfg[p/4][8*(p%4) +: 8];
      if (f[0] && int'(f[3:1]) == c) begin
        if (kind == 0)      r[p] = 1'b1;
        else if (kind == 1) r[p] = 1'b0;
        else                r[p] = ~pins[p];
      end
    end
    return r;
  endfunction

  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input logic tv, input logic [4:0] tid, input logic [2:0] ra,
                      input string req, input logic pre_chk);
    @(negedge clk);
    cfg_we = we; cfg_waddr = wa; cfg_wdata = wd;
    task_valid = tv; task_id = tid; cfg_raddr = ra;
    if (pre_chk) begin
      #1;
      chk(pin_out == m_pin, "R11 no change before edge", pin_out, m_pin);
    end
    @(posedge clk);
    m_pin = model_next(m_pin, tv, tid);
    if (we) m_cfg[wa] = wd & 32'h0F0F0F0F;
    #1;
    chk(pin_out == m_pin, req, pin_out, m_pin);
    @(negedge clk);
    cfg_we = 1'b0; task_valid = 1'b0;
    #0.1;
    chk(cfg_rdata == m_cfg[ra], {req, " readback"}, cfg_rdata, m_cfg[ra]);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd4242);
    rst_n = 1'b0; cfg_we = 0; cfg_waddr = 0; cfg_wdata = 0; cfg_raddr = 0;
    task_valid = 0; task_id = 0;
    for (int i = 0; i < 8; i++) m_cfg[i] = '0;
    m_pin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(pin_out == 32'h0, "R1 outputs low", pin_out, 32'h0);
    for (int a = 0; a < 8; a++) begin
      cfg_raddr = 3'(a); #0.1;
      chk(cfg_rdata == 32'h0, "R1 config zero", cfg_rdata, 32'h0);
    end

    // pins 0,1 on ch2 enabled, pin2 ch3 enabled, pin3 ch2 disabled; reserved bits set
    step(1, 3'd0, 32'hF4F7F5F5, 0, 5'd0, 3'd0, "R2 R3 write word0", 0);
    chk(cfg_rdata == 32'h04070505, "R3 reserved zero", cfg_rdata, 32'h04070505);
    // pin 13 (word3, lane1) on ch7 enabled: byte 0x0F at bits 15:8
    step(1, 3'd3, 32'h00000F00, 0, 5'd0, 3'd3, "R2 packing word3", 0);
    step(0, 3'd0, 32'h0, 1, 5'd3, 3'd0, "R4 R9 set ch2", 1);
    chk(pin_out == 32'h00000003, "R9 R8 fan-out", pin_out, 32'h3);
    step(0, 3'd0, 32'h0, 1, 5'd19, 3'd0, "R6 toggle ch2", 1);
    chk(pin_out == 32'h0, "R6 toggled low", pin_out, 32'h0);
    step(0, 3'd0, 32'h0, 1, 5'd19, 3'd0, "R6 toggle ch2 again", 0);
    step(0, 3'd0, 32'h0, 1, 5'd4, 3'd0, "R4 set ch3", 0);
    step(0, 3'd0, 32'h0, 1, 5'd8, 3'd3, "R4 set ch7 pin13", 0);
    chk(pin_out == 32'h00002007, "R4 R2 pin13", pin_out, 32'h00002007);
    step(0, 3'd0, 32'h0, 1, 5'd12, 3'd0, "R5 clear ch3", 0);
    chk(pin_out[2] == 1'b0, "R5 pin2 low", {31'd0, pin_out[2]}, 32'h0);
    step(0, 3'd0, 32'h0, 1, 5'd0, 3'd0, "R7 id 0", 0);
    step(0, 3'd0, 32'h0, 1, 5'd25, 3'd0, "R7 id 25", 0);
    step(0, 3'd0, 32'h0, 1, 5'd31, 3'd0, "R7 id 31", 0);
    chk(pin_out == 32'h00002003, "R7 unchanged", pin_out, 32'h00002003);
    step(0, 3'd0, 32'h0, 1, 5'd10, 3'd0, "R5 clear ch1 no pins", 0);
    // rebind pin0 to ch5 while clearing ch2: old binding applies
    step(1, 3'd0, 32'h0407050B, 1, 5'd11, 3'd0, "R10 write with pulse", 0);
    chk(pin_out[0] == 1'b0, "R10 old binding used", {31'd0, pin_out[0]}, 32'h0);
    step(0, 3'd0, 32'h0, 1, 5'd6, 3'd0, "R10 new binding ch5 set", 0);
    chk(pin_out[0] == 1'b1, "R10 new binding", {31'd0, pin_out[0]}, 32'h1);

    for (int i = 0; i < 3000; i++) begin
      logic we = ($urandom % 4) == 0;
      logic [31:0] wd = $urandom | ($urandom & 32'h01010101);
      step(we, 3'($urandom), wd, ($urandom % 4) != 0, 5'($urandom), 3'($urandom),
           "R11 R4 R5 R6 R7 R8 random", (i % 8) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule